// File: doc/BRIEF.md
# Layer Clip Window Register File

This block stores four rectangular clip windows, one for each display layer: the bitmap layer, the sprite layer, the base pixel layer and the tile layer. Each window is a set of four 8-bit coordinates: left edge X1, right edge X2, top edge Y1 and bottom edge Y2. Software reaches all four coordinates of a window through one data register. A hidden per-window pointer selects which coordinate that register accesses. A fifth register packs the four pointers into one byte and can send any of them back to X1. The renderer reads the windows from four parallel 32-bit outputs, so it never has to go through the register bus.

Each pointer is a four-state machine with the states `SEL_X1`, `SEL_X2`, `SEL_Y1` and `SEL_Y2`. There are three transitions:
- **advance**: a write to the window register moves the pointer to the next state in the order X1, X2, Y1, Y2.
- **wrap**: a write while the pointer is in `SEL_Y2` moves it back to `SEL_X1`.
- **clear**: a set bit in a write to the pointer register forces the pointer to `SEL_X1`.

A read never changes the state. The read port is registered: read data appears one clock after the read strobe and holds its value until the next read.

Top module: `layer_clip_regs`

## Requirements
- R1: The window registers sit at address 0x18 (bitmap), 0x19 (sprite), 0x1A (base pixel) and 0x1B (tile). A write to one of them changes only that window's coordinates and pointer.
- R2: A write stores the data into the coordinate that the window's pointer selects. The pointer then advances in the order X1, X2, Y1, Y2. Each 32-bit window output is packed as Y2 in [31:24], Y1 in [23:16], X2 in [15:8] and X1 in [7:0].
- R3: A read of a window register returns, one clock after the strobe, the coordinate at the current pointer. The read leaves the pointer and all coordinates unchanged.
- R4: A write made while the pointer is at Y2 wraps the pointer back to X1.
- R5: Reset (active-low) sets all pointers to X1. The bitmap, sprite and base pixel windows return to X1=0, X2=255, Y1=0, Y2=191. The tile window returns to X1=0, X2=159, Y1=0, Y2=255. Read data resets to 0x00.
- R6: A read of address 0x1C returns the four 2-bit pointers packed as tile in [7:6], base pixel in [5:4], sprite in [3:2] and bitmap in [1:0]. The encoding is X1=0, X2=1, Y1=2, Y2=3, so pointers of 0, 1, 2 and 3 read back as 0xE4.
- R7: In a write to 0x1C, data bits 0, 1, 2 and 3 reset the bitmap, sprite, base pixel and tile pointers to X1. Any combination of these bits may be set in one write. Bits 7:4 are ignored. No coordinate changes.
- R8: A read of any other address returns 0x00. A write to any other address changes no coordinate and no pointer.
- R9: When a read and a write strike the same address in the same cycle, the read returns the value from before the write. Between reads, the read data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| clip_bitmap_o | output | 32 | Bitmap window {Y2,Y1,X2,X1} |
| clip_sprite_o | output | 32 | Sprite window {Y2,Y1,X2,X1} |
| clip_base_o | output | 32 | Base pixel window {Y2,Y1,X2,X1} |
| clip_tile_o | output | 32 | Tile window {Y2,Y1,X2,X1} |

## Verification
Two functions can fall in the same cycle: a read capturing a register and a write updating it. The bench raises the read and write strobes together on a window register and on the pointer register. It then judges the returned byte against the value from before the write. A follow-up read must show that the write did land: the pointer advanced or was cleared, and the coordinate output changed.

// File: rtl/clip_regs_pkg.sv
package clip_regs_pkg;

    localparam int COORD_W = 8;
    localparam int NUM_WIN = 4;
    localparam int SEL_W   = 2;
    localparam int WIN_W   = 4 * COORD_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_X1 = 2'd0,
        SEL_X2 = 2'd1,
        SEL_Y1 = 2'd2,
        SEL_Y2 = 2'd3
    } coord_sel_e;

    typedef enum logic [2:0] {
        RD_WIN0 = 3'd0,
        RD_WIN1 = 3'd1,
        RD_WIN2 = 3'd2,
        RD_WIN3 = 3'd3,
        RD_CTRL = 3'd4,
        RD_NONE = 3'd5
    } rd_src_e;

    typedef struct packed {
        logic [COORD_W-1:0] y2;
        logic [COORD_W-1:0] y1;
        logic [COORD_W-1:0] x2;
        logic [COORD_W-1:0] x1;
    } window_t;

    function automatic window_t make_window(
        input logic [COORD_W-1:0] x1,
        input logic [COORD_W-1:0] x2,
        input logic [COORD_W-1:0] y1,
        input logic [COORD_W-1:0] y2
    );
        window_t w;
        w.x1 = x1;
        w.x2 = x2;
        w.y1 = y1;
        w.y2 = y2;
        return w;
    endfunction

endpackage

// File: rtl/clip_addr_decode.sv
module clip_addr_decode
    import clip_regs_pkg::*;
#(
    parameter logic [7:0] WIN_BASE  = 8'h18,
    parameter logic [7:0] CTRL_ADDR = 8'h1C
) (
    input  logic [7:0]         addr,
    input  logic               wr,
    output logic [NUM_WIN-1:0] win_wr,
    output logic               ctrl_wr,
    output rd_src_e            rd_src
);

    localparam logic [7:0] WIN_LAST = WIN_BASE + 8'(NUM_WIN - 1);

    logic       in_win;
    logic [7:0] offset;

    assign offset = addr - WIN_BASE;
    assign in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);

    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) begin
            win_wr[i] = wr && in_win && (offset == 8'(i));
        end
    end

    assign ctrl_wr = wr && (addr == CTRL_ADDR);

    always_comb begin
        if (in_win) begin
            unique case (offset[1:0])
                2'd0: rd_src = RD_WIN0;
                2'd1: rd_src = RD_WIN1;
                2'd2: rd_src = RD_WIN2;
                2'd3: rd_src = RD_WIN3;
            endcase
        end else if (addr == CTRL_ADDR) begin
            rd_src = RD_CTRL;
        end else begin
            rd_src = RD_NONE;
        end
    end

endmodule

// File: rtl/clip_window_slot.sv
module clip_window_slot
    import clip_regs_pkg::*;
#(
    parameter logic [WIN_W-1:0] RESET_WIN = 32'hBF00_FF00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               clr_en,
    input  logic [COORD_W-1:0] wdata,
    output logic [SEL_W-1:0]   sel_o,
    output logic [COORD_W-1:0] cur_o,
    output logic [WIN_W-1:0]   win_o
);

    coord_sel_e state_q, state_d;
    window_t    win_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_X1;
        else        state_q <= state_d;
    end

    // transitions: advance / wrap on write, clear on request
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                SEL_X1: state_d = SEL_X2;
                SEL_X2: state_d = SEL_Y1;
                SEL_Y1: state_d = SEL_Y2;
                SEL_Y2: state_d = SEL_X1;
            endcase
        end else if (clr_en) begin
            state_d = SEL_X1;
        end
    end

    // coordinate storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= window_t'(RESET_WIN);
        end else if (wr_en) begin
            unique case (state_q)
                SEL_X1: win_q.x1 <= wdata;
                SEL_X2: win_q.x2 <= wdata;
                SEL_Y1: win_q.y1 <= wdata;
                SEL_Y2: win_q.y2 <= wdata;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SEL_X1: cur_o = win_q.x1;
            SEL_X2: cur_o = win_q.x2;
            SEL_Y1: cur_o = win_q.y1;
            SEL_Y2: cur_o = win_q.y2;
        endcase
    end

    assign sel_o = state_q;
    assign win_o = win_q;

endmodule

// File: rtl/clip_read_port.sv
module clip_read_port
    import clip_regs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  rd_src_e                    rd_src,
    input  logic [NUM_WIN*COORD_W-1:0] cur_flat,
    input  logic [NUM_WIN*SEL_W-1:0]   sel_flat,
    output logic [COORD_W-1:0]         rdata
);

    logic [COORD_W-1:0] rd_next;

    always_comb begin
        unique case (rd_src)
            RD_WIN0: rd_next = cur_flat[0*COORD_W +: COORD_W];
            RD_WIN1: rd_next = cur_flat[1*COORD_W +: COORD_W];
            RD_WIN2: rd_next = cur_flat[2*COORD_W +: COORD_W];
            RD_WIN3: rd_next = cur_flat[3*COORD_W +: COORD_W];
            RD_CTRL: rd_next = COORD_W'(sel_flat);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_next;
    end

endmodule

// File: rtl/layer_clip_regs.sv
module layer_clip_regs
    import clip_regs_pkg::*;
#(
    parameter logic [7:0] WIN_BASE  = 8'h18,
    parameter logic [7:0] CTRL_ADDR = 8'h1C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_rd,
    output logic [7:0]  reg_rdata,
    output logic [31:0] clip_bitmap_o,
    output logic [31:0] clip_sprite_o,
    output logic [31:0] clip_base_o,
    output logic [31:0] clip_tile_o
);

    localparam window_t GFX_DEF  = make_window(8'd0, 8'd255, 8'd0, 8'd191);
    localparam window_t TILE_DEF = make_window(8'd0, 8'd159, 8'd0, 8'd255);
    localparam int      TILE_IDX = NUM_WIN - 1;

    logic [NUM_WIN-1:0]         win_wr;
    logic                       ctrl_wr;
    rd_src_e                    rd_src;
    logic [NUM_WIN*COORD_W-1:0] cur_flat;
    logic [NUM_WIN*SEL_W-1:0]   sel_flat;
    logic [NUM_WIN*WIN_W-1:0]   win_flat;

    clip_addr_decode #(
        .WIN_BASE  (WIN_BASE),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .addr    (reg_addr),
        .wr      (reg_wr),
        .win_wr  (win_wr),
        .ctrl_wr (ctrl_wr),
        .rd_src  (rd_src)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_slot
        localparam window_t DEF = (g == TILE_IDX) ? TILE_DEF : GFX_DEF;
        clip_window_slot #(
            .RESET_WIN (DEF)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (win_wr[g]),
            .clr_en (ctrl_wr && reg_wdata[g]),
            .wdata  (reg_wdata),
            .sel_o  (sel_flat[g*SEL_W +: SEL_W]),
            .cur_o  (cur_flat[g*COORD_W +: COORD_W]),
            .win_o  (win_flat[g*WIN_W +: WIN_W])
        );
    end

    clip_read_port u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (reg_rd),
        .rd_src   (rd_src),
        .cur_flat (cur_flat),
        .sel_flat (sel_flat),
        .rdata    (reg_rdata)
    );

    assign clip_bitmap_o = win_flat[0*WIN_W +: WIN_W];
    assign clip_sprite_o = win_flat[1*WIN_W +: WIN_W];
    assign clip_base_o   = win_flat[2*WIN_W +: WIN_W];
    assign clip_tile_o   = win_flat[3*WIN_W +: WIN_W];

endmodule

// File: rtl/clip_regs_checker.sv
module clip_regs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  reg_addr,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [7:0]  reg_rdata,
    input logic [31:0] clip_bitmap_o,
    input logic [31:0] clip_sprite_o,
    input logic [31:0] clip_base_o,
    input logic [31:0] clip_tile_o
);

    logic mapped;
    assign mapped = (reg_addr >= 8'h18) && (reg_addr <= 8'h1C);

    // R3: a read alone moves no coordinate
    a_r3_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr) |=> ($stable(clip_bitmap_o) && $stable(clip_sprite_o)
                                 && $stable(clip_base_o) && $stable(clip_tile_o)));

    // R1: a bitmap-window write leaves the other windows alone
    a_r1_window_isolation: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h18) |=> ($stable(clip_sprite_o)
            && $stable(clip_base_o) && $stable(clip_tile_o)));

    // R7: pointer register writes never alter coordinates
    a_r7_ctrl_keeps_coords: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h1C) |=> ($stable(clip_bitmap_o) && $stable(clip_sprite_o)
                                           && $stable(clip_base_o) && $stable(clip_tile_o)));

    // R8: unmapped reads return zero
    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !mapped) |=> (reg_rdata == 8'h00));

    // R8: unmapped writes change nothing
    a_r8_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !mapped) |=> ($stable(clip_bitmap_o) && $stable(clip_sprite_o)
                                 && $stable(clip_base_o) && $stable(clip_tile_o)));

    // R9: read data holds between reads
    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind layer_clip_regs clip_regs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_rdata     (reg_rdata),
    .clip_bitmap_o (clip_bitmap_o),
    .clip_sprite_o (clip_sprite_o),
    .clip_base_o   (clip_base_o),
    .clip_tile_o   (clip_tile_o)
);

// File: tb/layer_clip_regs_bench.sv
module layer_clip_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [31:0] clip_bitmap_o, clip_sprite_o, clip_base_o, clip_tile_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    layer_clip_regs u_layer_clip_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rd        (reg_rd),
        .reg_rdata     (reg_rdata),
        .clip_bitmap_o (clip_bitmap_o),
        .clip_sprite_o (clip_sprite_o),
        .clip_base_o   (clip_base_o),
        .clip_tile_o   (clip_tile_o)
    );

    // {write, addr, data, expected read}
    localparam int NV = 21;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h18, 8'h00, 8'h00},  // R5 X1 default
        {1'b0, 8'h18, 8'h00, 8'h00},  // R3 read again, pointer kept
        {1'b1, 8'h18, 8'h02, 8'h00},
        {1'b0, 8'h18, 8'h00, 8'hFF},  // R2 now at X2 default
        {1'b1, 8'h18, 8'hFE, 8'h00},
        {1'b0, 8'h1C, 8'h00, 8'h02},  // R6 bitmap pointer 2
        {1'b1, 8'h19, 8'h03, 8'h00},
        {1'b0, 8'h19, 8'h00, 8'hFF},  // R1 sprite X2 default
        {1'b0, 8'h1B, 8'h00, 8'h00},
        {1'b1, 8'h1B, 8'h01, 8'h00},
        {1'b0, 8'h1B, 8'h00, 8'h9F},  // R5 tile X2 default 159
        {1'b1, 8'h18, 8'h04, 8'h00},
        {1'b1, 8'h18, 8'hBE, 8'h00},
        {1'b0, 8'h18, 8'h00, 8'h02},  // R4 wrapped to X1
        {1'b1, 8'h1A, 8'h00, 8'h00},
        {1'b1, 8'h1A, 8'hFC, 8'h00},
        {1'b1, 8'h1B, 8'h9B, 8'h00},
        {1'b1, 8'h1B, 8'h02, 8'h00},
        {1'b0, 8'h1C, 8'h00, 8'hE4},  // R6 pointers 0,1,2,3
        {1'b1, 8'h1C, 8'h04, 8'h00},
        {1'b0, 8'h1C, 8'h00, 8'hC4}   // R7 base pointer cleared
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5 reset state
        check("R5 bitmap", clip_bitmap_o, 32'hBF00_FF00);
        check("R5 sprite", clip_sprite_o, 32'hBF00_FF00);
        check("R5 base",   clip_base_o,   32'hBF00_FF00);
        check("R5 tile",   clip_tile_o,   32'hFF00_9F00);
        check("R5 rdata",  {24'h0, reg_rdata}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i][24], !VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
            if (!VEC[i][24])
                check($sformatf("vector %0d R1-R7 read", i), {24'h0, reg_rdata}, {24'h0, VEC[i][7:0]});
        end

        // R2 R4 R1 packed window outputs after the table
        check("R2 R4 bitmap window", clip_bitmap_o, 32'hBE04_FE02);
        check("R1 sprite window",    clip_sprite_o, 32'hBF00_FF03);
        check("R1 base window",      clip_base_o,   32'hBF00_FC00);
        check("R2 tile window",      clip_tile_o,   32'hFF02_9B01);

        // R7: tile bit plus ignored high bits
        bus(1'b1, 1'b0, 8'h1C, 8'hF8);
        check("R7 clears only tile", clip_tile_o, 32'hFF02_9B01);
        bus(1'b0, 1'b1, 8'h1C, 8'h00);
        check("R7 tile pointer cleared", {24'h0, reg_rdata}, 32'h04);

        // R8 unmapped access
        bus(1'b1, 1'b0, 8'h20, 8'h55);
        bus(1'b0, 1'b1, 8'h20, 8'h00);
        check("R8 unmapped read", {24'h0, reg_rdata}, 32'h0);
        check("R8 unmapped write", clip_bitmap_o, 32'hBE04_FE02);
        bus(1'b0, 1'b1, 8'h1C, 8'h00);
        check("R8 pointers unchanged", {24'h0, reg_rdata}, 32'h04);

        // R9 simultaneous read and write on a window register
        bus(1'b1, 1'b1, 8'h18, 8'h11);
        check("R9 read sees old X1", {24'h0, reg_rdata}, 32'h02);
        check("R9 write landed", clip_bitmap_o, 32'hBE04_FE11);
        @(negedge clk);
        check("R9 rdata holds", {24'h0, reg_rdata}, 32'h02);
        bus(1'b0, 1'b1, 8'h18, 8'h00);
        check("R9 pointer advanced", {24'h0, reg_rdata}, 32'hFE);

        // R9 simultaneous read and write on the pointer register
        bus(1'b1, 1'b1, 8'h1C, 8'h03);
        check("R9 ctrl read before clear", {24'h0, reg_rdata}, 32'h05);
        bus(1'b0, 1'b1, 8'h1C, 8'h00);
        check("R7 multi-bit clear", {24'h0, reg_rdata}, 32'h00);

        // R5 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R5 bitmap after reset", clip_bitmap_o, 32'hBF00_FF00);
        check("R5 tile after reset",   clip_tile_o,   32'hFF00_9F00);
        @(negedge clk);
        rst_n = 1'b1;
        bus(1'b0, 1'b1, 8'h19, 8'h00);
        check("R5 sprite pointer at X1", {24'h0, reg_rdata}, 32'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule